// File: doc/BRIEF.md
# Programmable Duty-Cycle Clock Divider

This block turns a fast reference clock into a slower periodic waveform. A divide ratio and a high-time count are taken from input pins while reset is held, and they then set the output period (in reference cycles) and the length of its high phase. A free-running modulo counter sets the period, and a registered compare against the high-time count shapes the waveform. Because the counter wraps at an arbitrary limit, the ratio need not be a power of two. With a 16-bit counter, a 50 MHz reference divided by 56818 gives roughly 880 Hz.

A second mode ignores the high-time count and gives an exact half-period high phase. For an even ratio, a register toggles at the half-period and full-period counts. For an odd ratio, a rising-edge compare register is combined through an AND with a helper register clocked on the falling edge. The helper cuts the last high cycle in half, so the high and low phases each last N/2 reference cycles. A one-cycle wrap pulse marks the start of every period.

The output is a waveform, not a data stream, so there is no valid/ready handshake. All pins are plain control and status pins.

Top module: `clkdiv_duty`

## Requirements
- R1: The internal count steps by one on every reference rising edge from 0 up to N-1 and then returns to 0. The output period is exactly N reference cycles for any N from 2 to 2^CNT_W-1.
- R2: In duty mode (mode_i = 0) with 0 < H < N, the output is high for exactly H reference cycles in each period.
- R3: In duty mode, H = 0 keeps the output constantly low, and H >= N keeps it constantly high.
- R4: In half mode (mode_i = 1) with an even N, the output is high for exactly N/2 reference cycles of each period. It changes level once at the half-period count and once at the wrap.
- R5: In half mode with an odd N, the output is high for exactly N/2 reference cycles, a whole number of cycles plus one half. The falling-edge helper register ends the high phase half a cycle before the next rising edge.
- R6: wrap_o is high for exactly one reference cycle per period, in the cycle where the count has just returned to 0.
- R7: While rst_ni is low, clk_o and wrap_o are 0 and ratio_i, high_i and mode_i are captured. Changes on those inputs after reset release have no effect on the period or the high time.
- R8: With the default CNT_W = 16, a ratio of 56818 and H = 17045 give a period of 56818 cycles and a high time of 17045 cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock. Both edges are used. |
| rst_ni | input | 1 | Synchronous active-low reset. Configuration is captured while it is low. |
| ratio_i | input | CNT_W | Divide ratio N (must be 2 or more). |
| high_i | input | CNT_W | High-time count H, used in duty mode. |
| mode_i | input | 1 | 0 = duty mode set by H, 1 = half mode. |
| clk_o | output | 1 | Divided waveform. |
| wrap_o | output | 1 | One-cycle pulse at the start of each period. |

## Verification
The assertions assume that the captured ratio is at least 2, because a ratio of 0 or 1 gives no valid counter limit. The stimulus therefore draws ratios from 2 upward, and the single large directed case stays below the 16-bit limit. The assertions also assume that the configuration pins can move freely while the block is running, since they must have no effect then. The bench changes ratio_i, high_i and mode_i in the middle of a run to exercise this. High time is measured at half-cycle resolution by sampling between the edges, which resolves the odd-ratio half mode exactly.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;
  typedef enum logic {
    SHAPE_DUTY = 1'b0,
    SHAPE_HALF = 1'b1
  } shape_e;
endpackage

// File: rtl/clkdiv_cfg.sv
`timescale 1ns/1ps
module clkdiv_cfg
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] ratio_i,
  input  logic [CNT_W-1:0] high_i,
  input  logic             mode_i,
  output logic [CNT_W-1:0] n_o,
  output logic [CNT_W-1:0] h_o,
  output shape_e           shape_o
);
  logic [CNT_W-1:0] n_q, h_q;
  shape_e           shape_q;

  // Capture the configuration only while reset is held.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      n_q     <= ratio_i;
      h_q     <= high_i;
      shape_q <= shape_e'(mode_i);
    end
  end

  assign n_o     = n_q;
  assign h_o     = h_q;
  assign shape_o = shape_q;

  AST_CFG_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_ni |=> ($stable(n_q) && $stable(h_q) && $stable(shape_q))); // R7
endmodule

// File: rtl/clkdiv_count.sv
`timescale 1ns/1ps
module clkdiv_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] n_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             last_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;
  logic [CNT_W-1:0] limit;

  assign limit  = n_i - 1'b1;
  assign last_o = (cnt_q == limit);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else if (last_o) begin
      cnt_q  <= '0;
      wrap_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      wrap_q <= 1'b0;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_i >= 2) |-> (cnt_q < n_i)); // R1
  AST_CNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_i >= 2 && cnt_q != limit) |=> (cnt_q == $past(cnt_q) + 1'b1)); // R1
  AST_WRAP_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (n_i >= 2 && wrap_q) |=> !wrap_q); // R6
endmodule

// File: rtl/clkdiv_shape.sv
`timescale 1ns/1ps
module clkdiv_shape
  import clkdiv_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter bit ODD_EN = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] n_i,
  input  logic [CNT_W-1:0] h_i,
  input  shape_e           shape_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             last_i,
  output logic             clk_o
);
  localparam int EXT_W = CNT_W + 1;

  logic [EXT_W-1:0] cnt_ext, thr;
  logic [CNT_W-1:0] half_pt;
  logic             cmp_q, tog_q, cut_q;
  logic             odd_n;

  assign cnt_ext = {1'b0, cnt_i};
  assign odd_n   = n_i[0];
  assign half_pt = (n_i >> 1) - 1'b1;
  // Duty mode compares against H; half mode against ceil(N/2).
  assign thr = (shape_i == SHAPE_HALF) ? (({1'b0, n_i} + 1'b1) >> 1) : {1'b0, h_i};

  // Rising-edge compare register: high while the count is below the threshold.
  always_ff @(posedge clk_i) begin
    if (!rst_ni) cmp_q <= 1'b0;
    else         cmp_q <= (cnt_ext < thr);
  end

  // Even-ratio half mode: toggle at the half-period and period ends.
  always_ff @(posedge clk_i) begin
    if (!rst_ni)                           tog_q <= 1'b0;
    else if (last_i || cnt_i == half_pt)   tog_q <= ~tog_q;
  end

  // Odd-ratio helper on the falling edge trims the last high cycle by half.
  generate
    if (ODD_EN) begin : g_odd
      always_ff @(negedge clk_i) begin
        if (!rst_ni) cut_q <= 1'b0;
        else         cut_q <= (cnt_ext != thr);
      end
    end else begin : g_no_odd
      assign cut_q = 1'b1;
    end
  endgenerate

  always_comb begin
    if (shape_i == SHAPE_DUTY) clk_o = cmp_q;
    else if (odd_n)            clk_o = cmp_q & cut_q;
    else                       clk_o = tog_q;
  end

  AST_DUTY_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shape_i == SHAPE_DUTY && h_i == '0) |-> !clk_o); // R3
  AST_TOGGLE_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (shape_i == SHAPE_HALF && !odd_n && n_i >= 2 && last_i) |=> (tog_q != $past(tog_q))); // R4
endmodule

// File: rtl/clkdiv_duty.sv
`timescale 1ns/1ps
module clkdiv_duty
  import clkdiv_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] ratio_i,
  input  logic [CNT_W-1:0] high_i,
  input  logic             mode_i,
  output logic             clk_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] n_q, h_q, cnt;
  shape_e           shape_q;
  logic             last;

  clkdiv_cfg #(.CNT_W(CNT_W)) u_cfg (
    .clk_i(clk_i), .rst_ni(rst_ni), .ratio_i(ratio_i), .high_i(high_i),
    .mode_i(mode_i), .n_o(n_q), .h_o(h_q), .shape_o(shape_q)
  );

  clkdiv_count #(.CNT_W(CNT_W)) u_count (
    .clk_i(clk_i), .rst_ni(rst_ni), .n_i(n_q), .cnt_o(cnt),
    .last_o(last), .wrap_o(wrap_o)
  );

  clkdiv_shape #(.CNT_W(CNT_W), .ODD_EN(1'b1)) u_shape (
    .clk_i(clk_i), .rst_ni(rst_ni), .n_i(n_q), .h_i(h_q), .shape_i(shape_q),
    .cnt_i(cnt), .last_i(last), .clk_o(clk_o)
  );
endmodule

// File: tb/clkdiv_duty_test.sv
`timescale 1ns/1ps
module clkdiv_duty_test;
  localparam int CNT_W = 16;

  logic             clk = 1'b0;
  logic             rst_ni = 1'b0;
  logic [CNT_W-1:0] ratio = 16'd4;
  logic [CNT_W-1:0] high = 16'd1;
  logic             mode = 1'b0;
  logic             clk_o, wrap_o;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  clkdiv_duty #(.CNT_W(CNT_W)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .ratio_i(ratio), .high_i(high),
    .mode_i(mode), .clk_o(clk_o), .wrap_o(wrap_o)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Expected high time in half-cycles.
  function automatic int exp_high_halves(input int n, input int h, input bit m);
    if (m) return n;
    if (h >= n) return 2 * n;
    return 2 * h;
  endfunction

  function automatic string req_of(input int n, input int h, input bit m);
    if (m) return (n % 2 == 1) ? "R5" : "R4";
    if (h == 0 || h >= n) return "R3";
    return "R2";
  endfunction

  task automatic sample(output bit a, output bit b, output bit w);
    @(posedge clk); #2;
    a = clk_o; w = wrap_o;
    @(negedge clk); #2;
    b = clk_o;
  endtask

  // One period window from wrap pulse to the next.
  task automatic measure(output int cyc, output int hi, output int wr);
    bit a, b, w;
    int guard = 0;
    do begin sample(a, b, w); guard++; end while (!w && guard < 70000);
    cyc = 0; hi = 0; wr = 0;
    do begin
      hi += int'(a) + int'(b);
      wr += int'(w);
      cyc++;
      sample(a, b, w);
    end while (!w && cyc < 70000);
  endtask

  task automatic apply_reset(input int n, input int h, input bit m);
    @(negedge clk);
    rst_ni = 1'b0; ratio = CNT_W'(n); high = CNT_W'(h); mode = m;
    repeat (3) @(posedge clk);
    #2;
    chk(clk_o == 1'b0, "R7", "clk_o in reset", int'(clk_o), 0);
    chk(wrap_o == 1'b0, "R7", "wrap_o in reset", int'(wrap_o), 0);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic run_case(input int n, input int h, input bit m, input string tag);
    int cyc, hi, wr;
    apply_reset(n, h, m);
    measure(cyc, hi, wr);
    chk(cyc == n, (tag != "") ? tag : "R1", "period", cyc, n);
    chk(hi == exp_high_halves(n, h, m), (tag != "") ? tag : req_of(n, h, m),
        "high half-cycles", hi, exp_high_halves(n, h, m));
    chk(wr == 1, "R6", "wrap cycles per period", wr, 1);
  endtask

  initial begin
    int cyc, hi, wr;
    void'($urandom(32'd5150));
    // Directed corners
    run_case(3, 0, 1'b1, "");       // R5 divide-by-3 half mode
    run_case(5, 0, 1'b1, "");       // R5
    run_case(4, 0, 1'b1, "");       // R4
    run_case(2, 0, 1'b1, "");       // R4 smallest ratio
    run_case(4, 1, 1'b0, "");       // R2
    run_case(5, 3, 1'b0, "");       // R2
    run_case(6, 0, 1'b0, "");       // R3 always low
    run_case(6, 6, 1'b0, "");       // R3 H equal to N
    run_case(5, 40, 1'b0, "");      // R3 H above N
    // R7: reconfigure while running has no effect
    apply_reset(7, 2, 1'b0);
    measure(cyc, hi, wr);
    ratio = 16'd3; high = 16'd1; mode = 1'b1;
    measure(cyc, hi, wr);
    chk(cyc == 7, "R7", "period after live input change", cyc, 7);
    chk(hi == 4, "R7", "high after live input change", hi, 4);
    // Constrained random
    for (int i = 0; i < 24; i++) begin
      int n = 2 + int'($urandom_range(38));
      int h = int'($urandom_range(45));
      bit m = bit'($urandom_range(1));
      run_case(n, h, m, "");
    end
    // R8 large ratio with 30 percent duty
    run_case(56818, 17045, 1'b0, "R8");
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule